// File: doc/BRIEF.md
# Monochrome LCD Command Decoder

This block is the receiving end of a small monochrome LCD controller. A host sends 8-bit words over a serial link (clock, data, active-low select) and uses a data/command line to mark each word. Command words update controller state: a bank bit that chooses between two instruction sets, power-down, addressing direction, bias, contrast, the first display line, the display mode, and the column (X) and page (Y) write pointers. Data words are stored in a display memory of 102 columns by 8 pages, one vertical 8-pixel strip per word, and the write pointer then moves on.

The serial pins are brought into the system clock domain through a two-flop synchroniser and sampled on rising serial-clock edges, so the system clock must run several times faster than the serial clock. The same opcode prefix decodes differently per bank: a word with bit 7 set loads X in the basic bank and contrast in the extended bank. A registered read port lets a scan engine fetch any stored word.

Top module: `lcd_cmd_decoder`

## Requirements
- R1: After synchronous reset (rst_n low) the bank bit is 0, power-down is 1, vertical mode is 0, and bias, contrast, start line, display mode, X and Y are all 0.
- R2: Words are shifted in most significant bit first on rising sclk edges while cs_n is low; dc is taken from the eighth edge only; raising cs_n discards a partly received word.
- R3: A command 0b00100PVH, in either bank, loads power-down from bit 2, vertical mode from bit 1 and the bank bit from bit 0.
- R4: A command with bit 7 set loads X from bits 6..0 when the bank bit is 0, and loads contrast from bits 6..0 when the bank bit is 1, leaving the other register unchanged.
- R5: With bank bit 0, a command 0b01000yyy loads Y with yyy.
- R6: With bank bit 1, a command 0b00010bbb loads the 3-bit bias with bbb.
- R7: With bank bit 1, a command 0b000001xs sets start-line bit 6 to s and a command 0b01llllll sets start-line bits 5..0 to llllll.
- R8: With bank bit 0, a command 0b00001D0E loads the 2-bit display mode as {D,E}; a word of that shape with bit 1 set is ignored.
- R9: A data word is written at column X, page Y; the read port returns the word stored at (rd_col, rd_page) one clock after the address is presented.
- R10: In horizontal mode each data word increments X; from X=101 it goes to X=0 and Y increments, and Y wraps from 7 to 0.
- R11: In vertical mode each data word increments Y; from Y=7 it goes to Y=0 and X increments, and X wraps from 101 to 0.
- R12: Commands that match no entry of the current bank (for example 0x00, or an opcode of the other bank) change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock from host |
| cs_n | input | 1 | Active-low select |
| mosi | input | 1 | Serial data, MSB first |
| dc | input | 1 | 1 = data word, 0 = command word |
| bank_ext | output | 1 | Extended instruction bank selected |
| power_down | output | 1 | Power-down state |
| vert_mode | output | 1 | 1 = vertical addressing |
| bias | output | 3 | Bias system value |
| contrast | output | 7 | Contrast value |
| start_line | output | 7 | First display line |
| disp_mode | output | 2 | Display mode {D,E} |
| x_addr | output | 7 | Column write pointer |
| y_addr | output | 3 | Page write pointer |
| rd_col | input | 7 | Read port column |
| rd_page | input | 3 | Read port page |
| rd_data | output | 8 | Stored word at the read address |

## Verification
A pin change on sclk passes two synchroniser flops and an edge register, so the received word is flagged on the third clock after the eighth rising sclk and the registers and memory take it on the fourth; a read returns one clock after the address is set. The bench drives each serial half-period for four clocks, leaves eight idle clocks after every word and samples on the falling clock edge, so every register check lands well after its update and before the next word can start. Read-back waits two clocks after placing the address.

// File: rtl/lcd_cmd_pkg.sv
// Shared constants for the LCD command decoder.
// Assumes: 8-bit command words; opcode shapes are fixed by the protocol.
package lcd_cmd_pkg;
    localparam int WORD_W     = 8;
    localparam int CONTRAST_W = 7;
    localparam int BIAS_W     = 3;
    localparam int START_W    = 7;
    localparam int DMODE_W    = 2;

    // One received word as handed from the serial front end to the decoder.
    typedef struct packed {
        logic              is_data;
        logic [WORD_W-1:0] val;
    } rx_word_t;
endpackage

// File: rtl/lcd_spi_rx.sv
// Serial front end: synchronises sclk/cs_n/mosi/dc to clk, shifts bits
// MSB first on rising sclk, and emits one-cycle word strobes.
// Assumes: clk is at least ~4x faster than sclk; cs_n high clears the count.
module lcd_spi_rx
    import lcd_cmd_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sclk,
    input  logic     cs_n,
    input  logic     mosi,
    input  logic     dc,
    output logic     word_vld,
    output rx_word_t word_out
);
    localparam int CNT_W = $clog2(WORD_W);

    logic [3:0]        sync1, sync2;   // {sclk, cs_n, mosi, dc}
    logic              sclk_prev;
    logic [CNT_W-1:0]  bit_cnt;
    logic [WORD_W-2:0] shift_q;
    logic              sclk_rise, sel_active;

    // Two-flop synchroniser plus previous sclk for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1     <= 4'b0100;
            sync2     <= 4'b0100;
            sclk_prev <= 1'b0;
        end else begin
            sync1     <= {sclk, cs_n, mosi, dc};
            sync2     <= sync1;
            sclk_prev <= sync2[3];
        end
    end

    assign sclk_rise  = sync2[3] & ~sclk_prev;
    assign sel_active = ~sync2[2];

    // Bit counter and shift register; word completes on the eighth edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            shift_q  <= '0;
            word_vld <= 1'b0;
            word_out <= '0;
        end else begin
            word_vld <= 1'b0;
            if (!sel_active) begin
                bit_cnt <= '0;
            end else if (sclk_rise) begin
                shift_q <= {shift_q[WORD_W-3:0], sync2[1]};
                if (bit_cnt == CNT_W'(WORD_W-1)) begin
                    bit_cnt          <= '0;
                    word_vld         <= 1'b1;
                    word_out.val     <= {shift_q, sync2[1]};
                    word_out.is_data <= sync2[0];
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |=> !word_vld);
    assert_desel_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_active |=> (bit_cnt == '0) && !word_vld);
endmodule

// File: rtl/lcd_cmd_regs.sv
// Command decoder and register file with the write-pointer logic.
// Bank bit chooses the instruction set; data words produce a memory write
// at the current pointer and advance it in the selected direction.
// Assumes: word_vld is a single-cycle strobe.
module lcd_cmd_regs
    import lcd_cmd_pkg::*;
#(
    parameter  int COLS  = 102,
    parameter  int PAGES = 8,
    localparam int XW    = $clog2(COLS),
    localparam int YW    = $clog2(PAGES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  word_vld,
    input  rx_word_t              word_in,
    output logic                  bank_q,
    output logic                  pd_q,
    output logic                  vert_q,
    output logic [BIAS_W-1:0]     bias_q,
    output logic [CONTRAST_W-1:0] contrast_q,
    output logic [START_W-1:0]    start_q,
    output logic [DMODE_W-1:0]    dmode_q,
    output logic [XW-1:0]         x_q,
    output logic [YW-1:0]         y_q,
    output logic                  wr_en,
    output logic [XW-1:0]         wr_col,
    output logic [YW-1:0]         wr_page,
    output logic [WORD_W-1:0]     wr_data
);
    logic          is_cmd, is_dat, x_last, y_last;
    logic [XW-1:0] x_next;
    logic [YW-1:0] y_next;
    logic [7:0]    v;

    assign v      = word_in.val;
    assign is_cmd = word_vld & ~word_in.is_data;
    assign is_dat = word_vld &  word_in.is_data;
    assign x_last = x_q >= XW'(COLS - 1);
    assign y_last = y_q >= YW'(PAGES - 1);

    // Next pointer position for the active addressing direction.
    always_comb begin
        x_next = x_q;
        y_next = y_q;
        if (!vert_q) begin
            x_next = x_last ? '0 : XW'(x_q + 1'b1);
            if (x_last) y_next = y_last ? '0 : YW'(y_q + 1'b1);
        end else begin
            y_next = y_last ? '0 : YW'(y_q + 1'b1);
            if (y_last) x_next = x_last ? '0 : XW'(x_q + 1'b1);
        end
    end

    // Memory write request at the current pointer, dropped if out of range.
    always_comb begin
        wr_en   = is_dat && (x_q < XW'(COLS)) && (32'(y_q) < PAGES);
        wr_col  = x_q;
        wr_page = y_q;
        wr_data = v;
    end

    // Register file: bank-dependent command decode and pointer update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q     <= 1'b0;
            pd_q       <= 1'b1;
            vert_q     <= 1'b0;
            bias_q     <= '0;
            contrast_q <= '0;
            start_q    <= '0;
            dmode_q    <= '0;
            x_q        <= '0;
            y_q        <= '0;
        end else if (is_dat) begin
            x_q <= x_next;
            y_q <= y_next;
        end else if (is_cmd) begin
            if (v[7:3] == 5'b00100) begin
                pd_q   <= v[2];
                vert_q <= v[1];
                bank_q <= v[0];
            end else if (bank_q) begin
                if (v[7])                        contrast_q     <= v[6:0];
                else if (v[7:3] == 5'b00010)     bias_q         <= v[2:0];
                else if (v[7:2] == 6'b000001)    start_q[6]     <= v[0];
                else if (v[7:6] == 2'b01)        start_q[5:0]   <= v[5:0];
            end else begin
                if (v[7])                        x_q <= XW'(v[6:0]);
                else if (v[7:3] == 5'b01000)     y_q <= YW'(v[2:0]);
                else if (v[7:3] == 5'b00001 && !v[1])
                                                 dmode_q <= {v[2], v[0]};
            end
        end
    end

    assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !word_vld |=> $stable(x_q) && $stable(y_q) && $stable(contrast_q)
                      && $stable(bias_q) && $stable(start_q) && $stable(dmode_q));
    assert_bank_split_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cmd && !bank_q && word_in.val[7]) |=> $stable(contrast_q));
    assert_horiz_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (is_dat && !vert_q && !x_last) |=> (x_q == XW'($past(x_q) + 1'b1)) && $stable(y_q));
    assert_vert_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (is_dat && vert_q && !y_last) |=> (y_q == YW'($past(y_q) + 1'b1)) && $stable(x_q));
endmodule

// File: rtl/lcd_disp_ram.sv
// Display memory, COLS x PAGES words, one write port and a registered read.
// Assumes: write address is in range whenever wr_en is high.
module lcd_disp_ram
    import lcd_cmd_pkg::*;
#(
    parameter  int COLS  = 102,
    parameter  int PAGES = 8,
    localparam int XW    = $clog2(COLS),
    localparam int YW    = $clog2(PAGES),
    localparam int DEPTH = COLS * PAGES,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [XW-1:0]     wr_col,
    input  logic [YW-1:0]     wr_page,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [XW-1:0]     rd_col,
    input  logic [YW-1:0]     rd_page,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_idx, rd_idx;

    assign wr_idx = AW'(wr_page) * AW'(COLS) + AW'(wr_col);
    assign rd_idx = AW'(rd_page) * AW'(COLS) + AW'(rd_col);

    // Write port: store a data word at its page/column slot.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
    end

    // Read port: one-cycle registered fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= mem[rd_idx];
    end

    assert_wr_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_col < XW'(COLS)) && (32'(wr_page) < PAGES));
endmodule

// File: rtl/lcd_cmd_decoder.sv
// Top level: serial receiver, command/register decoder and display memory.
// Assumes: synchronous active-low reset, clk well above sclk.
module lcd_cmd_decoder
    import lcd_cmd_pkg::*;
#(
    parameter  int COLS  = 102,
    parameter  int PAGES = 8,
    localparam int XW    = $clog2(COLS),
    localparam int YW    = $clog2(PAGES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sclk,
    input  logic                  cs_n,
    input  logic                  mosi,
    input  logic                  dc,
    output logic                  bank_ext,
    output logic                  power_down,
    output logic                  vert_mode,
    output logic [BIAS_W-1:0]     bias,
    output logic [CONTRAST_W-1:0] contrast,
    output logic [START_W-1:0]    start_line,
    output logic [DMODE_W-1:0]    disp_mode,
    output logic [XW-1:0]         x_addr,
    output logic [YW-1:0]         y_addr,
    input  logic [XW-1:0]         rd_col,
    input  logic [YW-1:0]         rd_page,
    output logic [WORD_W-1:0]     rd_data
);
    logic              word_vld, wr_en;
    rx_word_t          word;
    logic [XW-1:0]     wr_col;
    logic [YW-1:0]     wr_page;
    logic [WORD_W-1:0] wr_data;

    lcd_spi_rx u_rx (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .dc(dc), .word_vld(word_vld), .word_out(word)
    );

    lcd_cmd_regs #(.COLS(COLS), .PAGES(PAGES)) u_regs (
        .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .word_in(word),
        .bank_q(bank_ext), .pd_q(power_down), .vert_q(vert_mode),
        .bias_q(bias), .contrast_q(contrast), .start_q(start_line),
        .dmode_q(disp_mode), .x_q(x_addr), .y_q(y_addr),
        .wr_en(wr_en), .wr_col(wr_col), .wr_page(wr_page), .wr_data(wr_data)
    );

    lcd_disp_ram #(.COLS(COLS), .PAGES(PAGES)) u_ram (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_col(wr_col),
        .wr_page(wr_page), .wr_data(wr_data), .rd_col(rd_col),
        .rd_page(rd_page), .rd_data(rd_data)
    );
endmodule

// File: tb/lcd_cmd_decoder_tb.sv
module lcd_cmd_decoder_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, dc = 1'b0;
    logic       bank_ext, power_down, vert_mode;
    logic [2:0] bias;
    logic [6:0] contrast, start_line;
    logic [1:0] disp_mode;
    logic [6:0] x_addr;
    logic [2:0] y_addr;
    logic [6:0] rd_col = '0;
    logic [2:0] rd_page = '0;
    logic [7:0] rd_data;
    int tests = 0, fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    lcd_cmd_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .dc(dc), .bank_ext(bank_ext), .power_down(power_down),
        .vert_mode(vert_mode), .bias(bias), .contrast(contrast),
        .start_line(start_line), .disp_mode(disp_mode), .x_addr(x_addr),
        .y_addr(y_addr), .rd_col(rd_col), .rd_page(rd_page), .rd_data(rd_data)
    );

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Send one word; dc_early is driven on bits 1..7, dc_last on bit 8.
    task automatic send(input logic [7:0] b, input logic dc_early, input logic dc_last);
        cs_n = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            mosi = b[i];
            dc   = (i == 0) ? dc_last : dc_early;
            clks(4); sclk = 1'b1;
            clks(4); sclk = 1'b0;
        end
        clks(8);
    endtask

    task automatic cmd(input logic [7:0] b);  send(b, 1'b0, 1'b0); endtask
    task automatic dat(input logic [7:0] b);  send(b, 1'b1, 1'b1); endtask

    task automatic rd(input int c, input int p, input int exp, input string req);
        rd_col = 7'(c); rd_page = 3'(p);
        clks(2);
        check(req, int'(rd_data), exp);
    endtask

    function automatic int pat(input int c, input int p);
        return ((c * 7 + p * 13) ^ 8'h5A) & 8'hFF;
    endfunction

    initial begin
        clks(5); rst_n = 1'b1; clks(10);
        // R1 reset state
        check("R1 bank", bank_ext, 0);   check("R1 pd", power_down, 1);
        check("R1 vert", vert_mode, 0);  check("R1 bias", bias, 0);
        check("R1 contrast", contrast, 0); check("R1 start", start_line, 0);
        check("R1 dmode", disp_mode, 0); check("R1 x", x_addr, 0);
        check("R1 y", y_addr, 0);
        // R3 function set
        cmd(8'h26);
        check("R3 pd", power_down, 1); check("R3 vert", vert_mode, 1); check("R3 bank", bank_ext, 0);
        cmd(8'h21);
        check("R3 pd", power_down, 0); check("R3 vert", vert_mode, 0); check("R3 bank", bank_ext, 1);
        cmd(8'h20);
        check("R3 bank", bank_ext, 0);
        // R4 bank split of the bit-7 opcode
        cmd(8'h85);
        check("R4 x", x_addr, 5); check("R4 contrast", contrast, 0);
        cmd(8'h21);
        cmd(8'h85);
        check("R4 contrast", contrast, 5); check("R4 x held", x_addr, 5);
        for (int c = 0; c < 128; c++) begin
            cmd(8'h80 | 8'(c));
            check("R4 contrast sweep", contrast, c);
        end
        // R6 bias sweep
        for (int b = 0; b < 8; b++) begin
            cmd(8'h10 | 8'(b));
            check("R6 bias", bias, b);
        end
        // R7 start line
        cmd(8'h05); cmd(8'h4A);
        check("R7 start", start_line, 74);
        cmd(8'h04);
        check("R7 start hi clear", start_line, 10);
        check("R12 y held in ext bank", y_addr, 0);
        cmd(8'h0C);
        check("R12 dmode held in ext bank", disp_mode, 0);
        cmd(8'h20);
        // R5 Y sweep
        for (int y = 0; y < 8; y++) begin
            cmd(8'h40 | 8'(y));
            check("R5 y", y_addr, y);
        end
        // R8 display control
        cmd(8'h0C); check("R8 dmode", disp_mode, 2);
        cmd(8'h0D); check("R8 dmode", disp_mode, 3);
        cmd(8'h08); check("R8 dmode", disp_mode, 0);
        cmd(8'h0E); check("R8 bit1 ignored", disp_mode, 0);
        cmd(8'h09); check("R8 dmode", disp_mode, 1);
        // R12 other-bank and null opcodes
        cmd(8'h13); check("R12 bias held", bias, 7);
        cmd(8'h4A); check("R12 start held", start_line, 10);
        cmd(8'h00);
        check("R12 x held", x_addr, 5); check("R12 y held", y_addr, 7);
        check("R12 contrast held", contrast, 127); check("R12 dmode held", disp_mode, 1);
        // R2 partial word discarded on deselect
        cmd(8'h83);
        cs_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            mosi = 1'b1; clks(4); sclk = 1'b1; clks(4); sclk = 1'b0;
        end
        cs_n = 1'b1; clks(8);
        check("R2 no word on partial", x_addr, 3);
        cmd(8'h86);
        check("R2 aligned after deselect", x_addr, 6);
        // R2 dc taken on eighth edge only
        send(8'h87, 1'b1, 1'b0);
        check("R2 dc late cmd", x_addr, 7);
        // R9/R10 full horizontal sweep
        cmd(8'h80); cmd(8'h40);
        for (int p = 0; p < 8; p++) begin
            for (int c = 0; c < 102; c++) begin
                dat(8'(pat(c, p)));
                if (p == 0 && c == 101) begin
                    check("R10 x wrap", x_addr, 0); check("R10 y step", y_addr, 1);
                end
                if (p == 3 && c == 40) begin
                    check("R10 x inc", x_addr, 41); check("R10 y same", y_addr, 3);
                end
            end
        end
        check("R10 x final wrap", x_addr, 0); check("R10 y final wrap", y_addr, 0);
        for (int p = 0; p < 8; p++)
            for (int c = 0; c < 102; c++)
                rd(c, p, pat(c, p), "R9 readback");
        // R11 vertical addressing
        cmd(8'h22);
        check("R3 vert on", vert_mode, 1);
        cmd(8'h80 | 8'd100); cmd(8'h46);
        dat(8'hA1); check("R11 y inc", y_addr, 7); check("R11 x same", x_addr, 100);
        dat(8'hA2); check("R11 y wrap", y_addr, 0); check("R11 x inc", x_addr, 101);
        dat(8'hA3); check("R11 y", y_addr, 1); check("R11 x", x_addr, 101);
        rd(100, 6, 8'hA1, "R11 rd"); rd(100, 7, 8'hA2, "R11 rd"); rd(101, 0, 8'hA3, "R11 rd");
        cmd(8'h47);
        dat(8'hB4); check("R11 x wrap", x_addr, 0); check("R11 y wrap", y_addr, 0);
        rd(101, 7, 8'hB4, "R11 rd corner");
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule